// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Front End

This block sits behind the serial pins of a flash slave and decodes its one-byte commands. The serial clock, select and data lines are sampled with the system clock. Commands are taken MSB first on rising serial clock edges, which is SPI mode 0. Three commands are handled. Write enable arms a latch. Status read returns a status byte. Bulk erase starts a self-timed whole-array erase. The erase length in system clock cycles comes from an input.

The array contents are held elsewhere. When an erase cycle completes, the block sends a one-cycle strobe that tells the array to set every byte to FFh. An erase is refused in four cases: the latch is not armed, the select edge comes at the wrong bit count, any protection bit is set, or a cycle is already running. An active-low reset aborts a running erase. It then opens a recovery window, and any select that begins inside that window is not honoured.

Top module: `flash_erase_front`

## Requirements
- R1: After reset, the write-in-progress flag and the write enable latch are 0, `array_clear` is low, and a status read taken after the recovery window returns 00h.
- R2: A write enable frame (06h, exactly 8 bits, then select high) arms the write enable latch, which is status bit 1.
- R3: A status read (05h) shifts out the status byte MSB first, one bit per falling serial clock edge, starting on the falling edge that follows the opcode. The byte repeats while select stays low. Bit 0 is write-in-progress, bit 1 is the write enable latch, and bits 7..2 read 0.
- R4: A bulk erase (C7h, exactly 8 bits) with the latch armed starts the cycle on the rising edge of select. Write-in-progress is set and the latch is cleared at that start.
- R5: The cycle lasts `erase_len` clock cycles (0 is treated as 1). It ends with `array_clear` high for exactly one cycle, and write-in-progress returns to 0.
- R6: A bulk erase with the latch clear has no effect.
- R7: A bulk erase frame ended after 7 or after 9 bits has no effect, and the latch stays armed.
- R8: While a cycle runs, write enable and bulk erase frames are ignored. The running cycle keeps its length and gives a single strobe.
- R9: A bulk erase is refused while any bit of `region_lock` is 1, and the latch stays armed.
- R10: Reset low during a cycle aborts it: no strobe is issued, and the status reads 00h afterwards.
- R11: A select whose falling edge comes within `REC_CYCLES` cycles after reset release is ignored for its whole frame.
- R12: `spi_miso` is 0 whenever select was high at the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| region_lock | input | REGIONS | Per-region protection, any 1 blocks bulk erase |
| erase_len | input | CNT_W | Erase cycle length in clock cycles |
| array_clear | output | 1 | One-cycle strobe: set the whole array to FFh |

## Verification
The assertions check on every clock several conditions. An erase may only start on a select rising edge, with the latch armed and no protection bit set. A running cycle counts down without reloading. Each strobe coincides with the end of a cycle. No frame is honoured inside the recovery window, and `spi_miso` stays low while deselected. The bench scenarios cover what depends on whole frames. These are the exact bit-count rule, the repeating status byte and the measured erase length. They also cover the refusal of commands during a cycle, and the lost erase after a reset abort.

// File: rtl/flash_erase_front.sv
module flash_erase_front #(
  parameter int CNT_W = 24,
  parameter int REGIONS = 16,
  parameter int REC_CYCLES = 16,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_BULK = 8'hC7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [REGIONS-1:0] region_lock,
  input  logic [CNT_W-1:0]   erase_len,
  output logic               array_clear
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);

  logic             sclk_q, cs_q;
  logic [3:0]       bit_cnt;
  logic [7:0]       sh;
  logic             sel_ok, rd_mode;
  logic [2:0]       out_idx;
  logic             wel, wip;
  logic [CNT_W-1:0] cyc;
  logic [REC_W-1:0] rec_cnt;
  logic [7:0]       status;

  assign status = {6'b0, wel, wip};

  wire cs_fall   = ~spi_cs_n & cs_q;
  wire cs_rise   = spi_cs_n & ~cs_q;
  wire sclk_rise = spi_sclk & ~sclk_q & ~spi_cs_n & sel_ok;
  wire sclk_fall = ~spi_sclk & sclk_q & ~spi_cs_n & sel_ok;
  wire frame8    = cs_rise & sel_ok & (bit_cnt == 4'd8);
  wire do_wren   = frame8 & (sh == OP_WREN) & ~wip;
  wire do_bulk   = frame8 & (sh == OP_BULK) & wel & ~wip & ~(|region_lock);
  wire cyc_last  = wip & (cyc == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      bit_cnt     <= '0;
      sh          <= '0;
      sel_ok      <= 1'b0;
      rd_mode     <= 1'b0;
      out_idx     <= 3'd7;
      spi_miso    <= 1'b0;
      wel         <= 1'b0;
      wip         <= 1'b0;
      cyc         <= '0;
      rec_cnt     <= REC_W'(REC_CYCLES);
      array_clear <= 1'b0;
    end else begin
      sclk_q      <= spi_sclk;
      cs_q        <= spi_cs_n;
      array_clear <= 1'b0;
      if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;

      if (cs_fall) begin
        sel_ok  <= (rec_cnt == '0);
        bit_cnt <= '0;
        rd_mode <= 1'b0;
        out_idx <= 3'd7;
      end else if (cs_rise) begin
        sel_ok  <= 1'b0;
        rd_mode <= 1'b0;
      end

      if (sclk_rise) begin
        sh <= {sh[6:0], spi_mosi};
        if (bit_cnt != 4'hF) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 4'd7 && {sh[6:0], spi_mosi} == OP_RDSR) rd_mode <= 1'b1;
      end

      if (spi_cs_n) begin
        spi_miso <= 1'b0;
      end else if (sclk_fall && rd_mode) begin
        spi_miso <= status[out_idx];
        out_idx  <= out_idx - 1'b1;
      end

      if (do_wren) wel <= 1'b1;

      if (do_bulk) begin
        wip <= 1'b1;
        wel <= 1'b0;
        cyc <= (erase_len == '0) ? CNT_W'(1) : erase_len;
      end else if (cyc_last) begin
        wip         <= 1'b0;
        array_clear <= 1'b1;
      end else if (wip) begin
        cyc <= cyc - 1'b1;
      end
    end
  end

  a_r4_start_on_select_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise) && !wel);
  a_r6_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  a_r9_start_needs_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(region_lock) == '0));
  a_r8_cycle_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> (cyc == $past(cyc) - 1'b1));
  a_r5_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    array_clear |-> (!wip && $past(wip)));
  a_r11_no_frame_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_cnt != '0) |-> !sel_ok);
  a_r12_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_cs_n) |-> !spi_miso);
endmodule

// File: tb/test_flash_erase_front.sv
module test_flash_erase_front;
  localparam int H = 3;
  localparam int N = 600;
  localparam int REC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, clr;
  logic [15:0] lock = '0;
  logic [23:0] elen = 24'(N);

  int total = 0, bad = 0, strobes = 0;
  int tcount = 0, strobe_t = 0, rise_t = 0;
  logic [15:0] rd;

  flash_erase_front #(.REC_CYCLES(REC)) i_flash_erase_front (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .region_lock(lock),
    .erase_len(elen), .array_clear(clr));

  always #5 clk = ~clk;
  always @(posedge clk) tcount++;
  always @(negedge clk) if (clr) begin strobes++; strobe_t = tcount; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int ncmd, input int nrd, output logic [15:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < ncmd; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'b0;
      repeat (H) @(negedge clk); sclk = 1'b1;
      repeat (H) @(negedge clk); sclk = 1'b0;
    end
    for (int i = 0; i < nrd; i++) begin
      mosi = 1'b0;
      repeat (H) @(negedge clk); sclk = 1'b1; r = {r[14:0], miso};
      repeat (H) @(negedge clk); sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0; rise_t = tcount;
    repeat (4) @(negedge clk);
  endtask

  task automatic status(output logic [7:0] s);
    logic [15:0] r;
    xfer(8'h05, 8, 8, r);
    s = r[7:0];
  endtask

  task automatic pulse_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 strobe idle", clr, 1'b0);
    chk("R12 miso idle", miso, 1'b0);
    repeat (REC + 10) @(negedge clk);
    status(s);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_no_latch();
    logic [7:0] s;
    xfer(8'hC7, 8, 0, rd);
    repeat (N + 20) @(negedge clk);
    chk("R6 no strobe without latch", strobes, 0);
    status(s);
    chk("R6 status unchanged", s, 8'h00);
  endtask

  task automatic t_wren_and_read();
    xfer(8'h06, 8, 0, rd);
    xfer(8'h05, 8, 16, rd);
    chk("R2 latch set (first byte)", rd[15:8], 8'h02);
    chk("R3 status byte repeats", rd[7:0], 8'h02);
    chk("R12 miso low after frame", miso, 1'b0);
  endtask

  task automatic t_bit_count();
    logic [7:0] s;
    xfer(8'hC7, 7, 0, rd);
    xfer(8'hC7, 9, 0, rd);
    repeat (N + 20) @(negedge clk);
    chk("R7 no strobe on 7 or 9 bits", strobes, 0);
    status(s);
    chk("R7 latch still armed", s, 8'h02);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    lock = 16'h0020;
    xfer(8'hC7, 8, 0, rd);
    repeat (N + 20) @(negedge clk);
    chk("R9 no strobe while locked", strobes, 0);
    status(s);
    chk("R9 latch still armed", s, 8'h02);
    lock = '0;
  endtask

  task automatic t_erase();
    logic [7:0] s;
    int start;
    xfer(8'hC7, 8, 0, rd);
    start = rise_t;
    status(s);
    chk("R4 busy and latch cleared", s, 8'h01);
    xfer(8'h06, 8, 0, rd);
    xfer(8'hC7, 8, 0, rd);
    status(s);
    chk("R8 commands ignored while busy", s, 8'h01);
    repeat (N + 20) @(negedge clk);
    chk("R5 single strobe", strobes, 1);
    chk("R5 R8 cycle length kept", strobe_t - start, N + 1);
    status(s);
    chk("R5 idle after cycle", s, 8'h00);
    repeat (N) @(negedge clk);
    chk("R8 no late strobe", strobes, 1);
  endtask

  task automatic t_abort();
    logic [7:0] s;
    xfer(8'h06, 8, 0, rd);
    xfer(8'hC7, 8, 0, rd);
    repeat (50) @(negedge clk);
    pulse_reset();
    repeat (REC + 10) @(negedge clk);
    status(s);
    chk("R10 status after abort", s, 8'h00);
    repeat (N + 20) @(negedge clk);
    chk("R10 no strobe after abort", strobes, 1);
  endtask

  task automatic t_recovery();
    logic [7:0] s;
    pulse_reset();
    xfer(8'h06, 8, 0, rd);
    status(s);
    chk("R11 select in recovery ignored", s, 8'h00);
    xfer(8'h06, 8, 0, rd);
    status(s);
    chk("R11 select after recovery honoured", s, 8'h02);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R0 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_latch();
    t_wren_and_read();
    t_bit_count();
    t_protect();
    t_erase();
    t_abort();
    t_recovery();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule